// File: doc/BRIEF.md
# Fully Associative Page Translator

This block turns a 32-bit logical address into a 24-bit physical address. It keeps a 64-entry table. Each entry holds a logical page tag, a physical page frame and two protection bits. Every access compares its page tag with all entries at once. On a hit in mapped user state, the frame of the matching entry supplies the upper physical bits. The page offset always passes through unchanged.

Supervisor accesses skip translation, and so do user accesses while the mode bit or the force-unmapped input is set. In those cases the low 24 logical bits appear on the physical address as they are. In mapped user state, a missing page, a write to a write-protected page, or a non-fetch access to an execute-only page raises a bus-error request. The request and its cause flags appear one cycle after the strobed access, so that software can load the entry and restart the access. A simple indexed write port loads tags and frames.

Top module: `page_xlate_top`

## Requirements
- R1: In mapped user state, a valid entry whose tag equals la_i[31:12] gives hit_o=1, gives its index on hit_idx_o, and drives pa_o[23:12] with its frame.
- R2: pa_o[11:0] equals la_i[11:0] in every state.
- R3: When fc_i[2]=1 (supervisor), pa_o[23:12]=la_i[23:12], hit_o=0, hit_idx_o=0, and no bus error or cause flag follows.
- R4: In user state, mode_i=1 or force_unmap_i=1 gives the same pass-through as R3, with no hit, no bus error and no cause flag.
- R5: On a mapped user access that matches no valid entry, pa_o[23:12]=0 and hit_o=0. If as_i=1, berr_o=1 and miss_o=1 in the next cycle.
- R6: On a strobed hit where the entry's write-protect bit is set and rw_i=0 (write), berr_o and wp_fault_o are 1 in the next cycle. A read of that entry raises neither.
- R7: On a strobed hit where the entry's execute-only bit is set and fc_i[1:0] is not 2'b10 (program space), berr_o and ep_fault_o are 1 in the next cycle. An access with fc_i[1:0]=2'b10 raises neither. R6 and R7 may flag together.
- R8: When several valid entries carry the same tag, the lowest-numbered one wins both hit_idx_o and the frame.
- R9: After reset every entry is invalid. wr_frm_en_i loads frame=wr_data_i[11:0], execute-only=wr_data_i[12] and write-protect=wr_data_i[13], and marks the entry valid. wr_tag_en_i loads tag=wr_data_i[19:0] and leaves validity alone. A write is visible from the next cycle.
- R10: berr_o, miss_o, wp_fault_o and ep_fault_o are registered and are 0 after reset. In the cycle after an access with as_i=0, all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| la_i | input | 32 | Logical address |
| fc_i | input | 3 | Function code; bit 2 is supervisor, 2'b10 in bits 1..0 is program space |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_i | input | 1 | Address strobe; qualifies the fault checks |
| force_unmap_i | input | 1 | Forces user accesses to pass through |
| mode_i | input | 1 | Mode bit; 1 selects unmapped user state |
| wr_tag_en_i | input | 1 | Load the tag of entry wr_idx_i |
| wr_frm_en_i | input | 1 | Load the frame and protection bits of entry wr_idx_i and mark it valid |
| wr_idx_i | input | 6 | Entry index for a table write |
| wr_data_i | input | 20 | Write data (tag, or {wp, ep, frame}) |
| pa_o | output | 24 | Physical address |
| hit_o | output | 1 | Mapped lookup matched a valid entry |
| hit_idx_o | output | 6 | Index of the winning entry |
| berr_o | output | 1 | Registered bus-error request |
| miss_o | output | 1 | Registered cause: no matching entry |
| wp_fault_o | output | 1 | Registered cause: write-protect violation |
| ep_fault_o | output | 1 | Registered cause: execute-only violation |

## Verification
Lookups run with the same logical address under supervisor, mode-bit, force-unmapped and mapped user codes. This shows that only mapped user state consults the table. Tags are loaded without frames, then with frames, which separates validity from tag matching. Protected entries are hit with reads, writes, data accesses and program fetches, so each cause flag is tied to its own condition. Duplicate tags at low and high indices, and entries 0 and 63, test the priority encoder at both ends.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int LA_W  = 32;
    localparam int PA_W  = 24;
    localparam int OFF_W = 12;
    localparam int TAG_W = LA_W - OFF_W;
    localparam int FRM_W = PA_W - OFF_W;

    typedef struct packed {
        logic             vld;
        logic             wp;
        logic             ep;
        logic [FRM_W-1:0] frm;
        logic [TAG_W-1:0] tag;
    } pte_t;

    typedef struct packed {
        logic berr;
        logic miss;
        logic wp;
        logic ep;
    } fault_t;
endpackage

// File: rtl/xlate_table.sv
module xlate_table
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_tag_en,
    input  logic                    wr_frm_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [TAG_W-1:0]        wr_data,
    output pte_t [ENTRIES-1:0]      tbl_o
);
    pte_t [ENTRIES-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_tag_en) begin
            tbl_d[wr_idx].tag = wr_data;
        end
        if (wr_frm_en) begin
            tbl_d[wr_idx].frm = wr_data[FRM_W-1:0];
            tbl_d[wr_idx].ep  = wr_data[FRM_W];
            tbl_d[wr_idx].wp  = wr_data[FRM_W+1];
            tbl_d[wr_idx].vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign tbl_o = tbl_q;

    AST_FRM_WRITE_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_frm_en |=> tbl_q[$past(wr_idx)].vld); // R9

    AST_TAG_WRITE_KEEPS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tag_en && !wr_frm_en) |=> (tbl_q[$past(wr_idx)].vld == $past(tbl_q[wr_idx].vld))); // R9
endmodule

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  pte_t [ENTRIES-1:0]      tbl_i,
    input  logic [TAG_W-1:0]        tag_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o,
    output pte_t                    ent_o
);
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] below_mask;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl_i[g].vld && (tbl_i[g].tag == tag_i);
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = i[IDX_W-1:0];
            end
        end
    end

    assign ent_o      = tbl_i[idx_o];
    assign below_mask = ({{(ENTRIES-1){1'b0}}, 1'b1} << idx_o) - 1'b1;

    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> match[idx_o]); // R1

    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (match == '0)); // R5

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((match & below_mask) == '0)); // R8
endmodule

// File: rtl/xlate_fault.sv
module xlate_fault
    import xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   as_i,
    input  logic   mapped_i,
    input  logic   hit_i,
    input  logic   wp_i,
    input  logic   ep_i,
    input  logic   is_write_i,
    input  logic   is_fetch_i,
    output fault_t flt_o
);
    fault_t flt_d, flt_q;

    always_comb begin
        flt_d      = '0;
        if (as_i && mapped_i) begin
            flt_d.miss = !hit_i;
            flt_d.wp   = hit_i && wp_i && is_write_i;
            flt_d.ep   = hit_i && ep_i && !is_fetch_i;
        end
        flt_d.berr = flt_d.miss | flt_d.wp | flt_d.ep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign flt_o = flt_q;

    AST_MISS_RAISES_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (as_i && mapped_i && !hit_i) |=> (flt_q.berr && flt_q.miss)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |=> (flt_q == '0)); // R10

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_i |=> !flt_q.berr); // R3

    AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_q.miss, flt_q.wp | flt_q.ep})); // R7
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   la_i,
    input  logic [2:0]        fc_i,
    input  logic              rw_i,
    input  logic              as_i,
    input  logic              force_unmap_i,
    input  logic              mode_i,
    input  logic              wr_tag_en_i,
    input  logic              wr_frm_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [TAG_W-1:0]  wr_data_i,
    output logic [PA_W-1:0]   pa_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic              berr_o,
    output logic              miss_o,
    output logic              wp_fault_o,
    output logic              ep_fault_o
);
    pte_t [ENTRIES-1:0] tbl;
    pte_t               ent;
    fault_t             flt;
    logic               raw_hit;
    logic [IDX_W-1:0]   raw_idx;
    logic               mapped;
    logic [FRM_W-1:0]   frm_sel;

    xlate_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_tag_en (wr_tag_en_i),
        .wr_frm_en (wr_frm_en_i),
        .wr_idx    (wr_idx_i),
        .wr_data   (wr_data_i),
        .tbl_o     (tbl)
    );

    xlate_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .tbl_i (tbl),
        .tag_i (la_i[LA_W-1:OFF_W]),
        .hit_o (raw_hit),
        .idx_o (raw_idx),
        .ent_o (ent)
    );

    assign mapped = !fc_i[2] && !mode_i && !force_unmap_i;

    xlate_fault u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_i       (as_i),
        .mapped_i   (mapped),
        .hit_i      (raw_hit),
        .wp_i       (ent.wp),
        .ep_i       (ent.ep),
        .is_write_i (!rw_i),
        .is_fetch_i (fc_i[1:0] == 2'b10),
        .flt_o      (flt)
    );

    always_comb begin
        if (!mapped)      frm_sel = la_i[PA_W-1:OFF_W];
        else if (raw_hit) frm_sel = ent.frm;
        else              frm_sel = '0;
    end

    assign pa_o       = {frm_sel, la_i[OFF_W-1:0]};
    assign hit_o      = mapped && raw_hit;
    assign hit_idx_o  = hit_o ? raw_idx : '0;
    assign berr_o     = flt.berr;
    assign miss_o     = flt.miss;
    assign wp_fault_o = flt.wp;
    assign ep_fault_o = flt.ep;

    AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_i[2] || mode_i || force_unmap_i) |-> (pa_o[PA_W-1:OFF_W] == la_i[PA_W-1:OFF_W] && !hit_o)); // R4

    AST_WP_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (as_i && hit_o && ent.wp && !rw_i) |=> (berr_o && wp_fault_o)); // R6
endmodule

// File: tb/sim_page_xlate_top.sv
`timescale 1ns/1ps
module sim_page_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] la = '0;
    logic [2:0]  fc = '0;
    logic        rw = 1'b1, as_s = 1'b0, frc = 1'b0, mode = 1'b0;
    logic        wt = 1'b0, wf = 1'b0;
    logic [5:0]  widx = '0;
    logic [19:0] wdat = '0;
    logic [23:0] pa;
    logic        hit, berr, miss, wpf, epf;
    logic [5:0]  hidx;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;

    typedef struct {
        logic  berr, miss, wp, ep;
        string req;
    } exp_t;
    exp_t q[$];

    logic [19:0] m_tag [64];
    logic [11:0] m_frm [64];
    logic        m_wp  [64];
    logic        m_ep  [64];
    logic        m_vld [64];

    always #2.5 clk = ~clk;

    page_xlate_top u0 (
        .clk(clk), .rst_n(rst_n), .la_i(la), .fc_i(fc), .rw_i(rw), .as_i(as_s),
        .force_unmap_i(frc), .mode_i(mode), .wr_tag_en_i(wt), .wr_frm_en_i(wf),
        .wr_idx_i(widx), .wr_data_i(wdat), .pa_o(pa), .hit_o(hit), .hit_idx_o(hidx),
        .berr_o(berr), .miss_o(miss), .wp_fault_o(wpf), .ep_fault_o(epf)
    );

    task automatic step(input logic [31:0] a, input logic [2:0] f, input logic r,
                        input logic s, input logic md, input logic fu,
                        input logic t_en, input logic f_en, input logic [5:0] ix,
                        input logic [19:0] d, input string req);
        logic        mp, h, w_e, e_e;
        logic [5:0]  ei;
        logic [23:0] epa;
        exp_t        e;
        @(negedge clk);
        la = a; fc = f; rw = r; as_s = s; mode = md; frc = fu;
        wt = t_en; wf = f_en; widx = ix; wdat = d;
        mp = !f[2] && !md && !fu;
        h = 1'b0; ei = '0;
        for (int i = 63; i >= 0; i--) begin
            if (m_vld[i] && m_tag[i] == a[31:12]) begin h = 1'b1; ei = i[5:0]; end
        end
        if (!mp)    epa = a[23:0];
        else if (h) epa = {m_frm[ei], a[11:0]};
        else        epa = {12'h000, a[11:0]};
        if (!(mp && h)) ei = '0;
        #1;
        checks++;
        if (pa !== epa || hit !== (mp && h) || hidx !== ei) begin
            errors++;
            $display("FAIL %s/R2 lookup: pa=%h hit=%b idx=%0d expected pa=%h hit=%b idx=%0d",
                     req, pa, hit, hidx, epa, mp && h, ei);
        end
        w_e = s && mp && h && m_wp[ei] && !r;
        e_e = s && mp && h && m_ep[ei] && (f[1:0] != 2'b10);
        e.miss = s && mp && !h;
        e.wp = w_e; e.ep = e_e;
        e.berr = e.miss | w_e | e_e;
        e.req = req;
        q.push_back(e);
        if (t_en) m_tag[ix] = d;
        if (f_en) begin
            m_frm[ix] = d[11:0]; m_ep[ix] = d[12]; m_wp[ix] = d[13]; m_vld[ix] = 1'b1;
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic [2:0] f, input logic r, input string req);
        step(a, f, r, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 20'd0, req);
    endtask

    task automatic wr(input logic t_en, input logic f_en, input logic [5:0] ix,
                      input logic [19:0] d, input string req);
        step(32'h0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, t_en, f_en, ix, d, req);
    endtask

    always @(posedge clk) begin
        if (started) begin
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (berr !== e.berr || miss !== e.miss || wpf !== e.wp || epf !== e.ep) begin
                    errors++;
                    $display("FAIL %s/R10 flags: berr=%b miss=%b wp=%b ep=%b expected %b %b %b %b",
                             e.req, berr, miss, wpf, epf, e.berr, e.miss, e.wp, e.ep);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_tag[i] = '0; m_frm[i] = '0; m_wp[i] = 0; m_ep[i] = 0; m_vld[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if ({berr, miss, wpf, epf} !== 4'b0000) begin
            errors++;
            $display("FAIL R10 reset: flags=%b expected 0000", {berr, miss, wpf, epf});
        end
        started = 1'b1;
        // R9: empty table misses, tag without frame still misses
        acc(32'h1234_5678, 3'b001, 1'b1, "R9");
        acc(32'h0000_0000, 3'b001, 1'b1, "R9");
        wr(1'b1, 1'b0, 6'd5, 20'h12345, "R9");
        acc(32'h1234_5678, 3'b001, 1'b1, "R9");
        wr(1'b0, 1'b1, 6'd5, 20'h00ABC, "R9");
        acc(32'h1234_5678, 3'b001, 1'b1, "R1");
        acc(32'h1234_5FFF, 3'b010, 1'b0, "R1");
        // R3 supervisor and R4 forced pass-through
        acc(32'hFFFF_F123, 3'b101, 1'b1, "R3");
        acc(32'h1234_5678, 3'b110, 1'b0, "R3");
        step(32'h1234_5678, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 20'd0, "R4");
        step(32'h9999_9000, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 20'd0, "R4");
        // R5 miss and R10 unstrobed miss
        acc(32'h9999_9ABC, 3'b001, 1'b1, "R5");
        step(32'h9999_9ABC, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 20'd0, "R10");
        // R6 write protect on entry 63
        wr(1'b1, 1'b0, 6'd63, 20'hCAFE0, "R6");
        wr(1'b0, 1'b1, 6'd63, 20'h02111, "R6");
        acc(32'hCAFE_0010, 3'b001, 1'b0, "R6");
        acc(32'hCAFE_0010, 3'b001, 1'b1, "R6");
        acc(32'hCAFE_0010, 3'b101, 1'b0, "R3");
        // R7 execute only on entry 0
        wr(1'b1, 1'b0, 6'd0, 20'h00001, "R7");
        wr(1'b0, 1'b1, 6'd0, 20'h01222, "R7");
        acc(32'h0000_1004, 3'b001, 1'b1, "R7");
        acc(32'h0000_1004, 3'b010, 1'b1, "R7");
        acc(32'h0000_1004, 3'b001, 1'b0, "R7");
        // R8 duplicate tags
        wr(1'b1, 1'b1, 6'd20, 20'h00333, "R8");
        wr(1'b1, 1'b0, 6'd20, 20'h00001, "R8");
        acc(32'h0000_1ABC, 3'b010, 1'b1, "R8");
        wr(1'b1, 1'b0, 6'd40, 20'h55555, "R8");
        wr(1'b0, 1'b1, 6'd40, 20'h00AAA, "R8");
        wr(1'b1, 1'b0, 6'd7, 20'h55555, "R8");
        wr(1'b0, 1'b1, 6'd7, 20'h00777, "R8");
        acc(32'h5555_5321, 3'b001, 1'b1, "R8");
        // R6 and R7 together
        wr(1'b1, 1'b0, 6'd9, 20'h77777, "R7");
        wr(1'b0, 1'b1, 6'd9, 20'h03444, "R7");
        acc(32'h7777_7000, 3'b001, 1'b0, "R6");
        acc(32'h7777_7000, 3'b010, 1'b1, "R7");
        step(32'h7777_7000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 20'd0, "R10");
        acc(32'hABCD_E5A5, 3'b001, 1'b1, "R2");
        wr(1'b0, 1'b0, 6'd0, 20'h0, "R10");
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule